// File: doc/BRIEF.md
# Pseudo Reed-Muller Expansion Engine

This block turns the truth vector of a Boolean function of up to four variables into a pseudo Reed-Muller coefficient vector. It does this by expanding one variable per tree level. At every internal node of the expansion tree it applies either a positive Davio step or a negative Davio step. It reports three results: the leaf coefficients, one expansion-choice bit per internal node, and the number of product terms in the resulting expression.

Two selection policies are available, chosen by `mode` when a run is started. The plain policy is a greedy one: at each node it takes the expansion whose two children hold fewer ones in total. The next-state policy treats the first variable as the clock of a level-triggered state machine. It fixes the positive expansion at the root and on the whole left half of the tree, so that the "hold" behaviour for clock low stays intact. Only the nodes below the root's right child use the greedy rule.

A run starts with a single-cycle `start`. Every internal node of one level is evaluated in the same clock, so the results appear after `NVARS` clocks and are held until the next run.

Top module: `prm_expand_top`

## Requirements
- R1: After reset, `busy`, `done`, `coef`, `choice` and `terms` are all zero.
- R2: `start` is accepted only while `busy` is low. `busy` is high from the edge after acceptance until `done` rises, and `done` rises on the `NVARS`-th rising edge after the accepting edge. A `start` seen while `busy` is high is ignored.
- R3: Bit i of `func_vec` is the function value for input combination i, with the first variable as the most significant bit of i. For the variable being expanded, the node's lower half is f0, its upper half is f1, and f2 = f0 XOR f1. A positive step sends f0 to the left child and f2 to the right child. A negative step sends f1 to the left child and f2 to the right child. Leaf j of the final level is `coef[j]`.
- R4: `choice[2^L - 1 + k]` is the decision for the node at position k (counted from the left) on level L. The value 1 means negative Davio and 0 means positive Davio.
- R5: In plain mode (`mode`=0), each node takes the expansion whose two children together contain fewer ones. On a tie it takes the positive expansion.
- R6: In next-state mode (`mode`=1), the root and every node below the root's left child use the positive expansion. The nodes below the right child follow the R5 rule.
- R7: While `done` is high, `terms` equals the number of ones in `coef`.
- R8: While `done` is high and no new run is accepted, `coef`, `choice` and `terms` stay unchanged.
- R9: `func_vec` and `mode` are sampled only on the accepting edge. Changes to them during a run have no effect on its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken when idle) |
| mode | input | 1 | 0 = plain greedy, 1 = next-state constrained |
| func_vec | input | 2^NVARS | Truth vector of the function |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid and held |
| coef | output | 2^NVARS | Coefficient vector (leaves) |
| choice | output | 2^NVARS-1 | Per-node expansion choice, 1 = negative |
| terms | output | clog2(2^NVARS+1) | Product-term count |

## Verification
A wrong split or a wrong expansion decision at any level changes the final leaves. The fault therefore shows up in `coef`, and usually in `terms`, as soon as `done` rises `NVARS` clocks after the start. A wrong node decision also shows up directly in its own `choice` bit. A broken level counter appears as `done` rising on the wrong cycle, or as a level being evaluated twice, and both are visible at the first completion. The constraint of next-state mode is observed through the `choice` bits of the left subtree and through the positive-only leaf pattern they produce.

// File: rtl/prm_pkg.sv
package prm_pkg;
  localparam int PRM_MAX_VARS = 4;
  localparam int PRM_MAX_LEN  = 1 << PRM_MAX_VARS;

  // number of ones in a zero-padded node vector
  function automatic int unsigned prm_ones(input logic [PRM_MAX_LEN-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < PRM_MAX_LEN; i++) n += int'(v[i]);
    return n;
  endfunction

  // node lies at the root or anywhere under the root's left child
  function automatic bit prm_on_left_path(input int level, input int pos);
    if (level == 0) return 1'b1;
    return ((pos >> (level - 1)) & 1) == 0;
  endfunction
endpackage

// File: rtl/prm_davio_node.sv
module prm_davio_node
  import prm_pkg::*;
#(
  parameter int W     = 2,
  parameter int LEVEL = 0,
  parameter int POS   = 0
) (
  input  logic         ns_mode,
  input  logic [W-1:0] node_in,
  output logic [W-1:0] node_out,
  output logic         use_nd
);
  localparam int H = W / 2;

  logic [H-1:0]             lo_half, hi_half, diff_half;
  logic [PRM_MAX_LEN-1:0]   lo_pad, hi_pad, diff_pad;
  logic                     forced_pd;
  int unsigned              cost_pd, cost_nd;

  assign lo_half   = node_in[H-1:0];
  assign hi_half   = node_in[W-1:H];
  assign diff_half = lo_half ^ hi_half;

  always_comb begin
    lo_pad   = '0;
    hi_pad   = '0;
    diff_pad = '0;
    lo_pad[H-1:0]   = lo_half;
    hi_pad[H-1:0]   = hi_half;
    diff_pad[H-1:0] = diff_half;
  end

  assign forced_pd = ns_mode && prm_on_left_path(LEVEL, POS);
  assign cost_pd   = prm_ones(lo_pad) + prm_ones(diff_pad);
  assign cost_nd   = prm_ones(hi_pad) + prm_ones(diff_pad);
  assign use_nd    = !forced_pd && (cost_nd < cost_pd);
  assign node_out  = {diff_half, (use_nd ? hi_half : lo_half)};
endmodule

// File: rtl/prm_level.sv
module prm_level #(
  parameter int NVARS = 4,
  parameter int LEVEL = 0
) (
  input  logic                    ns_mode,
  input  logic [(1<<NVARS)-1:0]   lvl_in,
  output logic [(1<<NVARS)-1:0]   lvl_out,
  output logic [(1<<LEVEL)-1:0]   lvl_nd
);
  localparam int VLEN  = 1 << NVARS;
  localparam int NODES = 1 << LEVEL;
  localparam int W     = VLEN >> LEVEL;

  for (genvar k = 0; k < NODES; k++) begin : g_node
    prm_davio_node #(.W(W), .LEVEL(LEVEL), .POS(k)) u_node (
      .ns_mode  (ns_mode),
      .node_in  (lvl_in[k*W +: W]),
      .node_out (lvl_out[k*W +: W]),
      .use_nd   (lvl_nd[k])
    );
  end
endmodule

// File: rtl/prm_expand_top.sv
module prm_expand_top
  import prm_pkg::*;
#(
  parameter int NVARS = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic                               mode,
  input  logic [(1<<NVARS)-1:0]              func_vec,
  output logic                               busy,
  output logic                               done,
  output logic [(1<<NVARS)-1:0]              coef,
  output logic [(1<<NVARS)-2:0]              choice,
  output logic [$clog2((1<<NVARS)+1)-1:0]    terms
);
  localparam int VLEN = 1 << NVARS;
  localparam int NINT = VLEN - 1;
  localparam int LVW  = (NVARS > 1) ? $clog2(NVARS) : 1;
  localparam int TW   = $clog2(VLEN + 1);

  logic [VLEN-1:0] vec_q;
  logic [NINT-1:0] nd_q;
  logic [LVW-1:0]  lvl_q;
  logic            busy_q, done_q, mode_q;
  logic [TW-1:0]   terms_q;

  logic [VLEN-1:0] lv_out [NVARS];
  logic [NINT-1:0] lv_nd  [NVARS];

  // named internal events
  logic            accept, step_last;
  logic [VLEN-1:0] step_vec;
  logic [NINT-1:0] step_nd;
  logic [PRM_MAX_LEN-1:0] step_pad;

  for (genvar g = 0; g < NVARS; g++) begin : g_lvl
    localparam int NODES = 1 << g;
    logic [NODES-1:0] nd_bits;
    prm_level #(.NVARS(NVARS), .LEVEL(g)) u_level (
      .ns_mode (mode_q),
      .lvl_in  (vec_q),
      .lvl_out (lv_out[g]),
      .lvl_nd  (nd_bits)
    );
    assign lv_nd[g] = NINT'(nd_bits) << (NODES - 1);
  end

  always_comb begin
    step_vec = '0;
    step_nd  = '0;
    for (int l = 0; l < NVARS; l++) begin
      if (lvl_q == LVW'(l)) begin
        step_vec = lv_out[l];
        step_nd  = lv_nd[l];
      end
    end
    step_pad = '0;
    step_pad[VLEN-1:0] = step_vec;
  end

  assign accept    = start && !busy_q;
  assign step_last = busy_q && (lvl_q == LVW'(NVARS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q   <= '0;
      nd_q    <= '0;
      lvl_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mode_q  <= 1'b0;
      terms_q <= '0;
    end else if (accept) begin
      vec_q   <= func_vec;
      nd_q    <= '0;
      lvl_q   <= '0;
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      mode_q  <= mode;
      terms_q <= '0;
    end else if (busy_q) begin
      vec_q <= step_vec;
      nd_q  <= nd_q | step_nd;
      lvl_q <= lvl_q + 1'b1;
      if (step_last) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        terms_q <= TW'(prm_ones(step_pad));
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign coef   = vec_q;
  assign choice = nd_q;
  assign terms  = terms_q;
endmodule

// File: rtl/prm_expand_chk.sv
module prm_expand_chk
  import prm_pkg::*;
#(
  parameter int NVARS = 4
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               start,
  input logic                               busy,
  input logic                               done,
  input logic [(1<<NVARS)-1:0]              coef,
  input logic [(1<<NVARS)-2:0]              choice,
  input logic [$clog2((1<<NVARS)+1)-1:0]    terms,
  input logic                               mode_q,
  input logic                               step_last
);
  localparam int NINT = (1 << NVARS) - 1;

  logic [NINT-1:0] left_mask;
  always_comb begin
    left_mask = '0;
    for (int l = 0; l < NVARS; l++)
      for (int k = 0; k < (1 << l); k++)
        if (prm_on_left_path(l, k)) left_mask[(1 << l) - 1 + k] = 1'b1;
  end

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));
  // R2
  run_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_last) |=> busy);
  // R2
  run_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_last |=> (done && !busy));
  // R7
  term_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(terms) == $countones(coef)));
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(coef) && $stable(choice) && $stable(terms)));
  // R6
  left_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q) |-> ((choice & left_mask) == '0));
  // R9
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_last) |=> $stable(mode_q));
endmodule

bind prm_expand_top prm_expand_chk #(.NVARS(NVARS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .coef      (coef),
  .choice    (choice),
  .terms     (terms),
  .mode_q    (mode_q),
  .step_last (step_last)
);

// File: tb/sim_prm_expand_top.sv
`timescale 1ns/1ps
module sim_prm_expand_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // 3-variable instance (exhaustive)
  logic        a_start = 0, a_mode = 0;
  logic [7:0]  a_vec = '0;
  logic        a_busy, a_done;
  logic [7:0]  a_coef;
  logic [6:0]  a_choice;
  logic [3:0]  a_terms;

  // 4-variable instance (sampled sweep)
  logic        b_start = 0, b_mode = 0;
  logic [15:0] b_vec = '0;
  logic        b_busy, b_done;
  logic [15:0] b_coef;
  logic [14:0] b_choice;
  logic [4:0]  b_terms;

  prm_expand_top #(.NVARS(3)) u0 (
    .clk(clk), .rst_n(rst_n), .start(a_start), .mode(a_mode), .func_vec(a_vec),
    .busy(a_busy), .done(a_done), .coef(a_coef), .choice(a_choice), .terms(a_terms));

  prm_expand_top #(.NVARS(4)) u1 (
    .clk(clk), .rst_n(rst_n), .start(b_start), .mode(b_mode), .func_vec(b_vec),
    .busy(b_busy), .done(b_done), .coef(b_coef), .choice(b_choice), .terms(b_terms));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int cnt1(input logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) if (v[i]) c++;
    return c;
  endfunction

  // reference: heap-ordered node array, full two-child cost sums
  task automatic model(input int n, input logic [15:0] v, input logic md,
                       output logic [15:0] e_coef, output logic [14:0] e_ch, output int e_terms);
    logic [15:0] nodes [31];
    int total = (1 << n) - 1;
    for (int i = 0; i < 31; i++) nodes[i] = '0;
    nodes[0] = v;
    e_ch = '0;
    for (int h = 0; h < total; h++) begin
      int lv = 0, w, hw, a;
      logic [15:0] msk, f0, f1, f2;
      bit forced, nd;
      while (((1 << (lv + 1)) - 1) <= h) lv++;
      w  = (1 << n) >> lv;
      hw = w / 2;
      msk = 16'((32'd1 << hw) - 1);
      f0 = nodes[h] & msk;
      f1 = (nodes[h] >> hw) & msk;
      f2 = f0 ^ f1;
      a = h;
      while (a > 2) a = (a - 1) / 2;
      forced = md && (h == 0 || a == 1);
      nd = !forced && ((cnt1(f1) + cnt1(f2)) < (cnt1(f0) + cnt1(f2)));
      e_ch[h] = nd;
      nodes[2*h+1] = nd ? f1 : f0;
      nodes[2*h+2] = f2;
    end
    e_coef = '0;
    for (int j = 0; j < (1 << n); j++) e_coef[j] = nodes[total + j][0];
    e_terms = cnt1(e_coef);
  endtask

  // one run; disturb = toggle start/inputs mid-run (R2, R9)
  task automatic run(input int n, input logic [15:0] v, input logic md, input bit disturb,
                     output logic [15:0] g_coef, output logic [14:0] g_ch, output int g_terms);
    logic d;
    @(negedge clk);
    if (n == 3) begin a_vec = v[7:0]; a_mode = md; a_start = 1; end
    else        begin b_vec = v;      b_mode = md; b_start = 1; end
    @(negedge clk);
    a_start = 0; b_start = 0;
    if (disturb) begin
      if (n == 3) begin a_vec = ~v[7:0]; a_mode = ~md; a_start = 1; end
      else        begin b_vec = ~v;      b_mode = ~md; b_start = 1; end
    end
    for (int i = 0; i < n - 1; i++) begin
      @(negedge clk);
      a_start = 0; b_start = 0;
    end
    d = (n == 3) ? a_done : b_done;
    chk(d == 1'b0, "R2 done early", 32'(d), 0);
    @(negedge clk);
    a_start = 0; b_start = 0;
    d = (n == 3) ? a_done : b_done;
    chk(d == 1'b1, "R2 done timing", 32'(d), 1);
    if (n == 3) begin g_coef = {8'h0, a_coef}; g_ch = {8'h0, a_choice}; g_terms = int'(a_terms); end
    else        begin g_coef = b_coef;         g_ch = b_choice;         g_terms = int'(b_terms); end
  endtask

  task automatic run_cmp(input int n, input logic [15:0] v, input logic md, input bit disturb, input string tag);
    logic [15:0] gc, ec;
    logic [14:0] gh, eh;
    int gt, et;
    run(n, v, md, disturb, gc, gh, gt);
    model(n, v, md, ec, eh, et);
    chk(gc == ec, {tag, " R3 coef"}, 32'(gc), 32'(ec));
    chk(gh == eh, {tag, md ? " R6 choice" : " R5 R4 choice"}, 32'(gh), 32'(eh));
    chk(gt == et, {tag, " R7 terms"}, 32'(gt), 32'(et));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] gc;
    logic [14:0] gh;
    int gt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!a_busy && !a_done, "R1 flags", {a_busy, a_done}, 0);
    chk(a_coef == 0 && a_choice == 0 && a_terms == 0, "R1 results", 32'(a_coef), 0);
    chk(!b_busy && !b_done && b_coef == 0 && b_choice == 0 && b_terms == 0, "R1 wide", 32'(b_coef), 0);
    rst_n = 1'b1;

    // R5 tie: constant one keeps positive everywhere
    run(3, 16'h00FF, 1'b0, 1'b0, gc, gh, gt);
    chk(gc == 16'h0001, "R5 tie coef", 32'(gc), 32'h1);
    chk(gh == 0, "R5 tie choice", 32'(gh), 0);
    chk(gt == 1, "R7 tie terms", gt, 1);

    // R4 R5: single minterm at combination 0 -> all-complemented term
    run(3, 16'h0001, 1'b0, 1'b0, gc, gh, gt);
    chk(gc == 16'h0080, "R3 minterm0 coef", 32'(gc), 32'h80);
    chk(gh == 15'h45, "R4 minterm0 choice", 32'(gh), 32'h45);
    chk(gt == 1, "R7 minterm0 terms", gt, 1);

    // R6: same vector in next-state mode
    run(3, 16'h0001, 1'b1, 1'b0, gc, gh, gt);
    chk(gc == 16'h008F, "R6 ns coef", 32'(gc), 32'h8F);
    chk(gh == 15'h44, "R6 ns choice", 32'(gh), 32'h44);
    chk(gt == 5, "R7 ns terms", gt, 5);

    // R8: hold while inputs wiggle without start
    a_vec = 8'h5A; a_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(a_done && a_coef == 8'h8F && a_choice == 7'h44 && a_terms == 4'd5,
        "R8 hold", 32'(a_coef), 32'h8F);

    // R2 R9: disturbed runs must equal undisturbed model
    run_cmp(3, 16'h00D8, 1'b0, 1'b1, "R9 disturbed3");
    run_cmp(3, 16'h00D8, 1'b1, 1'b1, "R2 R9 disturbed3ns");
    run_cmp(4, 16'hC3A5, 1'b0, 1'b1, "R9 disturbed4");
    run_cmp(4, 16'h0000, 1'b1, 1'b0, "R3 zero4");
    run_cmp(4, 16'hFFFF, 1'b0, 1'b0, "R5 ones4");

    // exhaustive 3-variable sweep, both modes
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 256; v++)
        run_cmp(3, 16'(v), m[0], 1'b0, "sweep3");

    // sampled 4-variable sweep, both modes
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 1200; i++)
        run_cmp(4, 16'((i * 40503) ^ (i << 5) ^ (m * 16'h1234)), m[0], 1'b0, "sweep4");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule